// File: doc/BRIEF.md
# External Bus Cycle Generator with Chip-Select Stretch

This block turns single read and write requests from inside the chip into cycles on an external asynchronous bus. It drives a registered address, an active-low select, separate active-low read and write strobes, and a shared bidirectional data bus. A plain access has two states, T1 then T2. The select and the matching strobe are low in both.

When the stretch bit is set as a request is taken, the access gains a select-only setup state (Th) before T1 and a select-only tail state (Tf) after T2. The strobes then always fall after the select falls and rise before it rises. On a write, the data stays on the bus through the tail state. This suits slow external write logic that latches on the edge of the select.

A request is taken only while the block is idle. Completion is reported by a one-cycle acknowledge. On a read, the acknowledge carries the data captured at the end of T2.

Top module: `xbus_cycle_gen`

## Requirements
- R1: After reset, busCsN, busRdN and busWrN are high, the data bus is not driven, rspAck is low and reqReady is high.
- R2: A read with stretch off holds busCsN and busRdN low for exactly two cycles, starting the cycle after acceptance. busWrN stays high. rspRdata equals the bus value present in the second of those cycles.
- R3: A write with stretch off holds busCsN and busWrN low for exactly two cycles. The block drives reqWdata on the data bus in those two cycles only, and releases the bus afterwards.
- R4: With stretch on, busCsN is low for four cycles. The strobe of the access is low only in the second and third of them.
- R5: A write with stretch on drives the data bus in the second, third and fourth select cycles, and not in the first.
- R6: busAddr equals the accepted reqAddr and stays unchanged in every cycle in which busCsN is low.
- R7: reqReady is high only while idle. A reqValid pulse while busy starts no access.
- R8: rspAck is high for exactly one cycle, the cycle right after the last select-low cycle, for both reads and writes.
- R9: busCsN is high for at least one cycle between two accesses issued back to back.
- R10: The stretch bit is sampled only when a request is accepted. Changing it during an access does not alter that access.
- R11: busRdN and busWrN are never low together, and neither is low while busCsN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgExtend | input | 1 | Enables the select-only setup and tail states |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Block idle; a request is taken this cycle |
| rspAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Captured read data |
| busAddr | output | ADDR_W | External address |
| busCsN | output | 1 | External select, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busData | inout | DATA_W | External data bus |

## Verification
The bench checks every cycle of each access against a window computed from the stretch and direction settings. A design that asserts a strobe in the setup state, or releases write data before the tail state, fails at once. It also flips the stretch bit in the middle of an access; a design that reads the live bit would cut the tail short or add a stray one. A read is captured from bench data that is present only while the read strobe is low, so capture on the wrong edge returns the pulled-up idle value. Back-to-back accesses and a request pulse during a busy cycle expose a missing idle gap, or an access started while busy.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_T1,
    S_T2,
    S_TAIL
  } busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // capture request fields (combinational, at accept)
    logic captureRd;  // sample bus at end of T2 (combinational)
    logic csN;        // registered pin values
    logic rdN;
    logic wrN;
    logic dataOe;     // registered drive enable for write data
  } busStrobes_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgExtend,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        rspAck,
  output busStrobes_t strobes
);

  busState_t state, nextState;
  logic extLatched, wrLatched;
  logic accept, wrNext, strobePhase, lastState;
  logic csNq, rdNq, wrNq, oeQ, ackQ;

  assign accept  = reqValid && (state == S_IDLE);
  assign wrNext  = accept ? reqWrite : wrLatched;
  assign reqReady = (state == S_IDLE);
  assign lastState = (state == S_TAIL) || (state == S_T2 && !extLatched);

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE:  if (accept) nextState = cfgExtend ? S_SETUP : S_T1;
      S_SETUP: nextState = S_T1;
      S_T1:    nextState = S_T2;
      S_T2:    nextState = extLatched ? S_TAIL : S_IDLE;
      S_TAIL:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign strobePhase = (nextState == S_T1) || (nextState == S_T2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      extLatched <= 1'b0;
      wrLatched  <= 1'b0;
      csNq       <= 1'b1;
      rdNq       <= 1'b1;
      wrNq       <= 1'b1;
      oeQ        <= 1'b0;
      ackQ       <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        extLatched <= cfgExtend;
        wrLatched  <= reqWrite;
      end
      csNq <= (nextState == S_IDLE);
      rdNq <= !(strobePhase && !wrNext);
      wrNq <= !(strobePhase && wrNext);
      oeQ  <= wrNext && (strobePhase || nextState == S_TAIL);
      ackQ <= lastState;
    end
  end

  assign rspAck = ackQ;

  always_comb begin
    strobes.loadReq   = accept;
    strobes.captureRd = (state == S_T2) && !wrLatched;
    strobes.csN       = csNq;
    strobes.rdN       = rdNq;
    strobes.wrN       = wrNq;
    strobes.dataOe    = oeQ;
  end

  // R11: strobes stay inside the select window and are exclusive
  a_r11_rd_in_cs: assert property (@(posedge clk) disable iff (!rstN) !rdNq |-> !csNq);
  a_r11_wr_in_cs: assert property (@(posedge clk) disable iff (!rstN) !wrNq |-> !csNq);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN) !(!rdNq && !wrNq));
  // R8: acknowledge is a single-cycle pulse
  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rstN) ackQ |=> !ackQ);
  // R7: ready only while the select is released
  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> csNq);
  // R4: setup and tail states carry select only
  a_r4_select_only: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SETUP || state == S_TAIL) |-> (!csNq && rdNq && wrNq));
  // R10: stretch setting frozen during an access
  a_r10_ext_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(extLatched));

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] wdOut,
  output logic [DATA_W-1:0] rspRdata
);

  localparam logic [ADDR_W-1:0] ADDR_RST = '0;
  localparam logic [DATA_W-1:0] DATA_RST = '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= ADDR_RST;
      wdOut    <= DATA_RST;
      rspRdata <= DATA_RST;
    end else begin
      if (strobes.loadReq) begin
        busAddr <= reqAddr;
        wdOut   <= reqWdata;
      end
      if (strobes.captureRd) rspRdata <= busDataIn;
    end
  end

  // R6: address held while the select is low
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.csN && !$past(strobes.csN)) |-> $stable(busAddr));
  // R5: write data driven only inside the select window
  a_r5_oe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataOe |-> !strobes.csN);
  // R3: never drive during a read strobe
  a_r3_oe_not_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dataOe |-> strobes.rdN);

endmodule

// File: rtl/xbus_cycle_gen.sv
module xbus_cycle_gen
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgExtend,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspAck,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busCsN,
  output logic              busRdN,
  output logic              busWrN,
  inout  wire  [DATA_W-1:0] busData
);

  busStrobes_t strobes;
  logic [DATA_W-1:0] wdOut;

  xbus_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgExtend (cfgExtend),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqReady  (reqReady),
    .rspAck    (rspAck),
    .strobes   (strobes)
  );

  xbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busDataIn (busData),
    .busAddr   (busAddr),
    .wdOut     (wdOut),
    .rspRdata  (rspRdata)
  );

  assign busCsN  = strobes.csN;
  assign busRdN  = strobes.rdN;
  assign busWrN  = strobes.wrN;
  assign busData = strobes.dataOe ? wdOut : {DATA_W{1'bz}};

endmodule

// File: tb/xbus_cycle_gen_test.sv
`timescale 1ns/1ps
module xbus_cycle_gen_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [DW-1:0] IDLE_BUS = {DW{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgExtend = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0, rdValue = '0;
  logic reqReady, rspAck, busCsN, busRdN, busWrN;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] busAddr;
  wire  [DW-1:0] busData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  for (genvar i = 0; i < DW; i++) begin : g_pull
    pullup (busData[i]);
  end
  assign busData = (!busRdN) ? rdValue : {DW{1'bz}};

  xbus_cycle_gen #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .cfgExtend(cfgExtend), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspAck(rspAck), .rspRdata(rspRdata),
    .busAddr(busAddr), .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busData(busData)
  );

  // fields: ext, write, flipMid, pokeBusy, addr, wdata, read value
  localparam int VW = 4 + AW + 2 * DW;
  localparam int NV = 7;
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000, 16'hA5A5},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'h2000, 16'h5A5A, 16'h0000},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'h3FF0, 16'h0000, 16'hC3C3},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h0004, 16'h1357, 16'h0000},
    {1'b1, 1'b1, 1'b1, 1'b1, 16'hABCD, 16'h2468, 16'h0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h7E7E},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runAccess(input bit ext, input bit wr, input bit flip, input bit poke,
                           input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                           input logic [DW-1:0] rv);
    int len, s;
    string tag;
    len = ext ? 4 : 2;
    s   = ext ? 1 : 0;
    tag = flip ? "R10" : (ext ? (wr ? "R5" : "R4") : (wr ? "R3" : "R2"));
    cfgExtend = ext; reqWrite = wr; reqAddr = addr; reqWdata = wd; rdValue = rv;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k <= len; k++) begin
      bit strobeOn, drive;
      logic [DW-1:0] expBus;
      if (k > 0) @(negedge clk);
      if (flip && k == 0) cfgExtend = !ext;
      if (poke && k == 0) reqValid = 1'b1;
      if (poke && k == 1) reqValid = 1'b0;
      strobeOn = (k >= s) && (k < s + 2);
      drive = wr && (k >= s) && (k < len);
      chk(busCsN == (k >= len), (k == len) ? "R9" : tag, busCsN, (k >= len));
      chk(busRdN == !(strobeOn && !wr), tag, busRdN, !(strobeOn && !wr));
      chk(busWrN == !(strobeOn && wr), tag, busWrN, !(strobeOn && wr));
      chk(!(!busRdN && !busWrN), "R11", {busRdN, busWrN}, 2'b11);
      chk(reqReady == (k == len), "R7", reqReady, (k == len));
      chk(rspAck == (k == len), "R8", rspAck, (k == len));
      if (k < len) chk(busAddr == addr, "R6", busAddr, addr);
      if (wr) expBus = drive ? wd : IDLE_BUS;
      else    expBus = strobeOn ? rv : IDLE_BUS;
      chk(busData == expBus, tag, busData, expBus);
      if (k == len && !wr) chk(rspRdata == rv, tag, rspRdata, rv);
    end
    if (poke) begin
      @(negedge clk);
      chk(busCsN == 1'b1, "R7", busCsN, 1);
      chk(reqReady == 1'b1, "R7", reqReady, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(busCsN == 1'b1, "R1", busCsN, 1);
    chk(busRdN == 1'b1, "R1", busRdN, 1);
    chk(busWrN == 1'b1, "R1", busWrN, 1);
    chk(rspAck == 1'b0, "R1", rspAck, 0);
    chk(reqReady == 1'b1, "R1", reqReady, 1);
    chk(busData == IDLE_BUS, "R1", busData, IDLE_BUS);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      runAccess(e[VW-1], e[VW-2], e[VW-3], e[VW-4],
                e[2*DW +: AW], e[DW +: DW], e[0 +: DW]);
    end
    // directed: idle after traffic, nothing asserted
    @(negedge clk);
    chk(busCsN == 1'b1 && rspAck == 1'b0, "R8", {busCsN, rspAck}, 2'b10);
    chk(busData == IDLE_BUS, "R3", busData, IDLE_BUS);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule